// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block owns the program counter and the three sticky condition flags (negative, zero, positive) of a small 16-bit processor. The sequencer pulses `fetch` once per instruction to step the PC to the following word. Later it pulses `execute` while the instruction word sits on `instr`. On that pulse the unit resolves a conditional branch, a register-indirect jump or a service trap, and the chosen target replaces the sequential value.

The flags change only when the register file reports a write from one of the value-producing opcodes. They take the sign and zero state of the value that was written. A jump or a trap placed between a flag-setting instruction and a later branch therefore leaves the flags untouched for that branch.

A trap writes the current (already stepped) PC to register 7 through a link port. It then holds a one-word memory read at the zero-extended 8-bit vector. The returned word becomes the new PC, and `busy` covers the whole wait.

Top module: `nextpc_unit`

## Requirements
- R1: While reset is asserted and just after it is released, the PC equals START_PC (default x3000), the flags read N=0 Z=1 P=0, and `busy`, `mem_req` and `link_we` are 0.
- R2: A `fetch` pulse without a redirect makes the PC one higher at the next edge. With neither strobe, the PC holds.
- R3: On `execute` with `instr[15:12]`=0000, bits 11, 10 and 9 select N, Z and P. If any selected flag is 1, the PC becomes PC + sign-extended `instr[8:0]`, where PC is the value already stepped by the earlier fetch. Examples: x4028 with Z set and `instr`=x04D9 gives x4101. x507C with N set and `instr`=x0985 gives x5001.
- R4: A branch whose selected flags are all 0 leaves the PC at its sequential value, which includes a same-cycle `fetch` step. A mask of 000 never redirects.
- R5: A branch with mask 111 always redirects.
- R6: On `execute` with `instr[15:12]`=1100, the PC loads the full 16-bit `reg_rdata`, and `reg_raddr` presents `instr[8:6]`.
- R7: On `execute` with `instr[15:12]`=1111, `link_we` is 1 in that cycle with `link_data` equal to the current PC. From the next cycle, `busy` and `mem_req` are 1 and `mem_addr` = {8'h00, `instr[7:0]`}.
- R8: While `busy` is 1, `fetch` and `execute` have no effect and the PC holds. A cycle with `mem_rvalid` loads `mem_rdata` into the PC and clears `busy` at the same edge.
- R9: When `reg_we` is 1 and `reg_wop` is one of 0001, 0101, 1001, 0010, 1010, 0110 or 1110, the flags become N = `reg_wdata[15]`, Z = (`reg_wdata`==0), P = neither.
- R10: The flags do not change when `reg_we` is 0 or `reg_wop` is any other code. Branch, jump and trap never alter them.
- R11: Exactly one of N, Z and P is 1 at all times.
- R12: On `execute`, any opcode other than 0000, 1100 and 1111 leaves the PC at its sequential value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch | input | 1 | Step PC to the next word |
| execute | input | 1 | Resolve the control transfer of `instr` |
| instr | input | 16 | Current instruction word |
| reg_rdata | input | 16 | Register-file read value for the jump base |
| reg_we | input | 1 | A general register is being written |
| reg_wop | input | 4 | Opcode of the writing instruction |
| reg_wdata | input | 16 | Value being written |
| mem_rvalid | input | 1 | Trap vector read has returned |
| mem_rdata | input | 16 | Returned service routine address |
| reg_raddr | output | 3 | Register index for the jump base |
| pc | output | 16 | Program counter |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_p | output | 1 | Positive flag |
| link_we | output | 1 | Write return address to register 7 |
| link_data | output | 16 | Return address |
| mem_req | output | 1 | Vector read outstanding |
| mem_addr | output | 16 | Vector read address |
| busy | output | 1 | Trap dispatch in progress |

## Verification
The properties assume that `mem_rvalid` arrives only while a trap read is outstanding, and that `reg_wop` carries a real opcode whenever `reg_we` is high. The stimulus never raises `mem_rvalid` outside the wait, and during the wait it drives both strobes to show that they have no effect. The bench places jumps between flag writes and branches so that flags persisting across non-writing instructions is actually exercised.

// File: rtl/nextpc_unit.sv
module nextpc_unit #(
  parameter logic [15:0] START_PC = 16'h3000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fetch,
  input  logic        execute,
  input  logic [15:0] instr,
  input  logic [15:0] reg_rdata,
  input  logic        reg_we,
  input  logic [3:0]  reg_wop,
  input  logic [15:0] reg_wdata,
  input  logic        mem_rvalid,
  input  logic [15:0] mem_rdata,
  output logic [2:0]  reg_raddr,
  output logic [15:0] pc,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_p,
  output logic        link_we,
  output logic [15:0] link_data,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  output logic        busy
);
  localparam logic [3:0] OP_BR   = 4'b0000;
  localparam logic [3:0] OP_JMP  = 4'b1100;
  localparam logic [3:0] OP_TRAP = 4'b1111;

  logic [15:0] pc_q, pc_d;
  logic        n_q, z_q, p_q, busy_q, sets_cc;
  logic [7:0]  vec_q;

  wire [3:0]  op      = instr[15:12];
  wire        act     = execute & ~busy_q;
  wire [15:0] seq_pc  = (fetch & ~busy_q) ? pc_q + 16'd1 : pc_q;
  wire [15:0] br_tgt  = pc_q + {{7{instr[8]}}, instr[8:0]};
  wire        br_take = (op == OP_BR) && |(instr[11:9] & {n_q, z_q, p_q});
  wire        trap_go = act && (op == OP_TRAP);

  always_comb begin
    case (reg_wop)
      4'b0001, 4'b0101, 4'b1001, 4'b0010,
      4'b1010, 4'b0110, 4'b1110: sets_cc = 1'b1;
      default:                   sets_cc = 1'b0;
    endcase
  end

  always_comb begin
    if (busy_q)                       pc_d = mem_rvalid ? mem_rdata : pc_q;
    else if (act && br_take)          pc_d = br_tgt;
    else if (act && op == OP_JMP)     pc_d = reg_rdata;
    else                              pc_d = seq_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= START_PC;
      n_q    <= 1'b0;
      z_q    <= 1'b1;
      p_q    <= 1'b0;
      busy_q <= 1'b0;
      vec_q  <= 8'h00;
    end else begin
      pc_q <= pc_d;
      if (reg_we && sets_cc) begin
        n_q <= reg_wdata[15];
        z_q <= (reg_wdata == 16'h0000);
        p_q <= ~reg_wdata[15] & (reg_wdata != 16'h0000);
      end
      if (trap_go) begin
        busy_q <= 1'b1;
        vec_q  <= instr[7:0];
      end else if (busy_q && mem_rvalid) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign reg_raddr = instr[8:6];
  assign pc        = pc_q;
  assign flag_n    = n_q;
  assign flag_z    = z_q;
  assign flag_p    = p_q;
  assign link_we   = trap_go;
  assign link_data = pc_q;
  assign mem_req   = busy_q;
  assign mem_addr  = {8'h00, vec_q};
  assign busy      = busy_q;
endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fetch,
  input logic        execute,
  input logic        reg_we,
  input logic        mem_rvalid,
  input logic [15:0] mem_rdata,
  input logic [15:0] pc,
  input logic        flag_n,
  input logic        flag_z,
  input logic        flag_p,
  input logic        link_we,
  input logic        busy
);
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({flag_n, flag_z, flag_p}) == 1); // R11

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable({flag_n, flag_z, flag_p})); // R10

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && fetch && !execute) |=> pc == $past(pc) + 16'd1); // R2

  AST_TRAP_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |=> busy); // R7

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_rvalid) |=> $stable(pc)); // R8

  AST_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_rvalid) |=> (!busy && pc == $past(mem_rdata))); // R8
endmodule

bind nextpc_unit nextpc_unit_chk i_chk (
  .clk(clk), .rst_n(rst_n), .fetch(fetch), .execute(execute),
  .reg_we(reg_we), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
  .pc(pc), .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p),
  .link_we(link_we), .busy(busy)
);

// File: tb/test_nextpc_unit.sv
module test_nextpc_unit;
  localparam time TCLK = 10ns;

  typedef struct packed {
    logic        f;
    logic        e;
    logic [15:0] ins;
    logic [15:0] rd;
    logic        we;
    logic [3:0]  wop;
    logic [15:0] wd;
    logic [15:0] xpc;
    logic [2:0]  xnzp;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,16'h0000,16'h0000,1'b0,4'h0,16'h0000,16'h3001,3'b010}, // R2 step
    '{1'b0,1'b0,16'h0000,16'h0000,1'b0,4'h0,16'h0000,16'h3001,3'b010}, // R2 hold
    '{1'b0,1'b0,16'h0000,16'h0000,1'b1,4'h1,16'h8000,16'h3001,3'b100}, // R9 negative
    '{1'b0,1'b1,16'h0805,16'h0000,1'b0,4'h0,16'h0000,16'h3006,3'b100}, // R3 n taken
    '{1'b1,1'b1,16'h0405,16'h0000,1'b0,4'h0,16'h0000,16'h3007,3'b100}, // R4 z not taken
    '{1'b0,1'b0,16'h0000,16'h0000,1'b1,4'h3,16'h0000,16'h3007,3'b100}, // R10 store code
    '{1'b0,1'b0,16'h0000,16'h0000,1'b1,4'hE,16'h0005,16'h3007,3'b001}, // R9 positive
    '{1'b0,1'b1,16'h03FF,16'h0000,1'b0,4'h0,16'h0000,16'h3006,3'b001}, // R3 backward
    '{1'b1,1'b1,16'h0005,16'h0000,1'b0,4'h0,16'h0000,16'h3007,3'b001}, // R4 mask 000
    '{1'b0,1'b1,16'h0F00,16'h0000,1'b0,4'h0,16'h0000,16'h2F07,3'b001}, // R5 always
    '{1'b0,1'b1,16'hC080,16'h6600,1'b0,4'h0,16'h0000,16'h6600,3'b001}, // R6 jump
    '{1'b0,1'b0,16'h0000,16'h0000,1'b1,4'h9,16'h0000,16'h6600,3'b010}, // R9 zero
    '{1'b1,1'b1,16'h1000,16'h0000,1'b0,4'h0,16'h0000,16'h6601,3'b010}, // R12 other op
    '{1'b0,1'b1,16'hC080,16'h4028,1'b0,4'h0,16'h0000,16'h4028,3'b010}, // R6 R10 jump keeps Z
    '{1'b0,1'b1,16'h04D9,16'h0000,1'b0,4'h0,16'h0000,16'h4101,3'b010}, // R3 example one
    '{1'b0,1'b0,16'h0000,16'h0000,1'b1,4'h1,16'hFFFF,16'h4101,3'b100}, // R9 negative
    '{1'b0,1'b1,16'hC080,16'h507C,1'b0,4'h0,16'h0000,16'h507C,3'b100}, // R6 jump
    '{1'b0,1'b1,16'h0985,16'h0000,1'b0,4'h0,16'h0000,16'h5001,3'b100}  // R3 example two
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic fetch = 0, execute = 0, reg_we = 0, mem_rvalid = 0;
  logic [15:0] instr = '0, reg_rdata = '0, reg_wdata = '0, mem_rdata = '0;
  logic [3:0]  reg_wop = '0;
  logic [2:0]  reg_raddr;
  logic [15:0] pc, link_data, mem_addr;
  logic flag_n, flag_z, flag_p, link_we, mem_req, busy;
  int nchk = 0, nbad = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  nextpc_unit i_nextpc_unit (
    .clk(clk), .rst_n(rst_n), .fetch(fetch), .execute(execute), .instr(instr),
    .reg_rdata(reg_rdata), .reg_we(reg_we), .reg_wop(reg_wop), .reg_wdata(reg_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .reg_raddr(reg_raddr), .pc(pc),
    .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p), .link_we(link_we),
    .link_data(link_data), .mem_req(mem_req), .mem_addr(mem_addr), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    fetch = 0; execute = 0; reg_we = 0; mem_rvalid = 0;
    instr = '0; reg_rdata = '0; reg_wop = '0; reg_wdata = '0; mem_rdata = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nbad++; nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pc in reset", pc, 16'h3000);
    chk("R1 flags in reset", {flag_n, flag_z, flag_p}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc after release", pc, 16'h3000);
    chk("R1 idle outputs", {busy, mem_req, link_we}, 3'b000);

    for (int i = 0; i < NV; i++) begin
      fetch = VECS[i].f; execute = VECS[i].e; instr = VECS[i].ins;
      reg_rdata = VECS[i].rd; reg_we = VECS[i].we; reg_wop = VECS[i].wop;
      reg_wdata = VECS[i].wd;
      @(negedge clk);
      chk($sformatf("vector %0d pc", i), pc, VECS[i].xpc);
      chk($sformatf("vector %0d flags", i), {flag_n, flag_z, flag_p}, VECS[i].xnzp);
    end
    idle();

    instr = 16'hC080; #1;
    chk("R6 reg_raddr", reg_raddr, 3'd2);

    // R7 trap at pc x5001, vector x25
    execute = 1; instr = 16'hF025; #1;
    chk("R7 link_we", link_we, 1'b1);
    chk("R7 link_data", link_data, 16'h5001);
    @(negedge clk); idle();
    chk("R7 busy", {busy, mem_req}, 2'b11);
    chk("R7 mem_addr", mem_addr, 16'h0025);
    // R8 strobes ignored while waiting
    fetch = 1; execute = 1; instr = 16'hC080; reg_rdata = 16'h1234;
    @(negedge clk); idle();
    chk("R8 pc held while busy", pc, 16'h5001);
    chk("R8 still busy", busy, 1'b1);
    mem_rvalid = 1; mem_rdata = 16'h0400;
    @(negedge clk); idle();
    chk("R8 pc from vector", pc, 16'h0400);
    chk("R8 busy cleared", busy, 1'b0);
    chk("R10 trap keeps flags", {flag_n, flag_z, flag_p}, 3'b100);

    // R1 reset in mid-run
    rst_n = 0;
    @(negedge clk);
    chk("R1 pc after mid reset", pc, 16'h3000);
    chk("R1 flags after mid reset", {flag_n, flag_z, flag_p}, 3'b010);
    rst_n = 1;
    @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule